// File: doc/BRIEF.md
# Two-Level Address Translation Walker

The walker turns a 32-bit virtual address into a physical address by fetching entries from a two-level mapping structure held in memory. A caller presents one request at a time: the virtual address, whether the access is a write, and whether it comes from user mode. The walker reads the first-level entry, which lies in a table located by a root frame input. That entry either maps a 4 MB region directly or points to a second-level table, whose entry maps a 4 KB page.

On success the response carries the physical address, a large-page flag, the low twelve bits of the final entry and the permission bits of both levels combined. A downstream checker can then decide whether the access is allowed. If a present bit is clear at either level, the response reports a not-present fault.

Entries that were used get their accessed bit set. The final entry also gets its modified bit set on a write. These updates go back to memory with a word write, and only when the entry value actually changes.

Top module: `pt_walker`

## Requirements
- R1: The first-level entry is read at address {root_frame, va[31:22], 2'b00}. The second-level entry is read at {first-level entry bits 31..12, va[21:12], 2'b00}.
- R2: A walk whose first-level entry has bit 0 = 1 and bit 7 = 0 ends at the second level. If the second-level entry has bit 0 = 1, resp_pa = {entry bits 31..12, va[11:0]} and resp_large = 0.
- R3: A first-level entry with bit 0 = 1 and bit 7 = 1 maps a 4 MB page. resp_pa = {entry bits 31..22, va[21:0]}, resp_large = 1, entry bits 21..12 are ignored, and no second read is made.
- R4: If bit 0 is clear in the entry read at either level, the response has resp_fault = 1. resp_pa, resp_large, resp_flags and resp_perm are all zero, and nothing is written to memory.
- R5: On a successful walk, bit 5 (accessed) is set in every entry used, and bit 6 (modified) is set in the final entry when req_write = 1. A first-level entry pointing to a table never gets bit 6 set by the walker. An entry is written back only if its value changes.
- R6: Write-backs happen only after every read of the walk. When both entries change, the first-level entry is written before the second-level entry.
- R7: resp_flags holds bits 11..0 of the final entry as updated by R5. resp_perm[1] is bit 2 (user) and resp_perm[0] is bit 1 (writable), each ANDed across all entries used.
- R8: req_ready is high only while idle, and request inputs are ignored while a walk is in progress. resp_valid is a one-cycle pulse, followed by req_ready the next cycle. resp_user repeats the req_user of the accepted request.
- R9: A read may complete any number of cycles (at least one) after it is issued. mem_rdata is taken only in a cycle where mem_rvalid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_frame | input | 20 | Physical frame of the first-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access from user mode |
| mem_req | output | 1 | Memory access issued this cycle |
| mem_we | output | 1 | Access is a word write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data |
| resp_valid | output | 1 | Response pulse |
| resp_fault | output | 1 | Not-present fault |
| resp_pa | output | 32 | Physical address |
| resp_large | output | 1 | 4 MB mapping used |
| resp_flags | output | 12 | Low bits of the updated final entry |
| resp_perm | output | 2 | Combined {user, writable} |
| resp_user | output | 1 | User flag of the request |

## Verification
The hardest case to reach is the one where both entries need a write-back and their order must be observed. This needs a table-pointing entry whose accessed bit is clear together with a present second-level entry that lacks accessed or modified. The sweep reaches it by stepping through every combination of entry kind, preset accessed and modified bits, write flag, and both levels' permission bits. Read latency is rotated across these walks. The memory model drives all-ones on the read data bus whenever mem_rvalid is low, and the bench keeps a different request asserted throughout each walk.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [19:0] root_frame,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic        req_write,
  input  logic        req_user,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        resp_valid,
  output logic        resp_fault,
  output logic [31:0] resp_pa,
  output logic        resp_large,
  output logic [11:0] resp_flags,
  output logic [1:0]  resp_perm,
  output logic        resp_user
);
  localparam int P_BIT = 0;
  localparam int A_BIT = 5;
  localparam int D_BIT = 6;
  localparam int L_BIT = 7;
  localparam logic [31:0] A_MSK = 32'(1) << A_BIT;
  localparam logic [31:0] D_MSK = 32'(1) << D_BIT;

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_WT1, S_RD2, S_WT2, S_WB1, S_WB2, S_RSP} st_t;

  st_t         st;
  logic [31:0] va, e1, e2;
  logic        wr, usr, flt, big;

  wire [31:0] e1_new = e1 | A_MSK | ((big && wr) ? D_MSK : 32'd0);
  wire [31:0] e2_new = e2 | A_MSK | (wr ? D_MSK : 32'd0);
  wire [31:0] a1     = {root_frame, va[31:22], 2'b00};
  wire [31:0] a2     = {e1[31:12], va[21:12], 2'b00};
  wire        rd_a_d = !mem_rdata[A_BIT] || (wr && !mem_rdata[D_BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      va  <= '0;
      e1  <= '0;
      e2  <= '0;
      wr  <= 1'b0;
      usr <= 1'b0;
      flt <= 1'b0;
      big <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va  <= req_va;
          wr  <= req_write;
          usr <= req_user;
          flt <= 1'b0;
          big <= 1'b0;
          st  <= S_RD1;
        end
        S_RD1: st <= S_WT1;
        S_WT1: if (mem_rvalid) begin
          e1 <= mem_rdata;
          if (!mem_rdata[P_BIT]) begin
            flt <= 1'b1;
            st  <= S_RSP;
          end else if (mem_rdata[L_BIT]) begin
            big <= 1'b1;
            st  <= rd_a_d ? S_WB1 : S_RSP;
          end else begin
            st <= S_RD2;
          end
        end
        S_RD2: st <= S_WT2;
        S_WT2: if (mem_rvalid) begin
          e2 <= mem_rdata;
          if (!mem_rdata[P_BIT]) begin
            flt <= 1'b1;
            st  <= S_RSP;
          end else if (!e1[A_BIT]) st <= S_WB1;
          else if (rd_a_d)         st <= S_WB2;
          else                     st <= S_RSP;
        end
        S_WB1: st <= (!big && e2_new != e2) ? S_WB2 : S_RSP;
        S_WB2: st <= S_RSP;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign mem_req    = (st == S_RD1) || (st == S_RD2) || (st == S_WB1) || (st == S_WB2);
  assign mem_we     = (st == S_WB1) || (st == S_WB2);
  assign mem_addr   = (st == S_RD1 || st == S_WB1) ? a1 : a2;
  assign mem_wdata  = (st == S_WB1) ? e1_new : e2_new;

  assign resp_valid = (st == S_RSP);
  assign resp_fault = flt;
  assign resp_large = !flt && big;
  assign resp_user  = usr;
  assign resp_pa    = flt ? 32'd0 : big ? {e1[31:22], va[21:0]} : {e2[31:12], va[11:0]};
  assign resp_flags = flt ? 12'd0 : big ? e1_new[11:0] : e2_new[11:0];
  assign resp_perm  = flt ? 2'd0 : big ? e1[2:1] : (e1[2:1] & e2[2:1]);

  a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  a_r5_wb_marks_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[A_BIT]);
  a_r4_fault_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_pa == 32'd0 && !resp_large && resp_flags == 12'd0));
  a_r8_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  a_r8_ready_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> req_ready);
  a_r8_accept_only_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> req_ready);
  a_r7_flags_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fault) |-> resp_flags[A_BIT] && resp_flags[P_BIT]);
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [19:0] root_frame = 20'h00001;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '1;
  logic        resp_valid, resp_fault, resp_large, resp_user;
  logic [31:0] resp_pa;
  logic [11:0] resp_flags;
  logic [1:0]  resp_perm;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .root_frame(root_frame),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_user(req_user),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_pa(resp_pa),
    .resp_large(resp_large), .resp_flags(resp_flags), .resp_perm(resp_perm),
    .resp_user(resp_user)
  );

  logic [31:0] mem [0:4095];
  logic [31:0] radr [0:3];
  logic [31:0] wadr [0:3];
  logic [31:0] wdat [0:3];
  int          rcnt = 0, wcnt = 0, lat = 1, wait_n = 0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    mem_rdata  <= 32'hFFFF_FFFF;
    if (mem_req && mem_we) begin
      mem[mem_addr[13:2]] <= mem_wdata;
      wadr[wcnt % 4] <= mem_addr;
      wdat[wcnt % 4] <= mem_wdata;
      wcnt <= wcnt + 1;
    end
    if (mem_req && !mem_we) begin
      radr[rcnt % 4] <= mem_addr;
      rcnt <= rcnt + 1;
      pend_addr <= mem_addr;
      pend <= 1'b1;
      wait_n <= lat - 1;
    end else if (pend) begin
      if (wait_n == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[pend_addr[13:2]];
        pend <= 1'b0;
      end else wait_n <= wait_n - 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset ready", 32'(req_ready), 32'd1);
    chk("R8 reset resp_valid", 32'(resp_valid), 32'd0);
    chk("R1 reset mem_req", 32'(mem_req), 32'd0);

    for (int n = 0; n < 512; n++) begin
      automatic int          kind = n & 3;
      automatic logic        a  = n[2], d = n[3], wr = n[4];
      automatic logic [1:0]  pp = n[6:5], qp = n[8:7];
      automatic logic        us = n[0] ^ n[3];
      automatic logic [19:0] tf = 20'(2 + n[0]);
      automatic logic [9:0]  i1 = 10'(n * 37 + 1), i2 = 10'(n * 91 + 5);
      automatic logic [11:0] off = 12'(n * 123);
      automatic logic [31:0] va = {i1, i2, off};
      automatic logic [31:0] e1a = {20'h00001, i1, 2'b00};
      automatic logic [31:0] e2a = {tf, i2, 2'b00};
      automatic logic [31:0] pde, pte, pde_n, pte_n, xpa;
      automatic logic [31:0] xwa [0:1];
      automatic logic [31:0] xwd [0:1];
      automatic logic [11:0] xfl;
      automatic logic [1:0]  xpm;
      automatic int          xnw = 0, xnr, r0, w0, t;
      automatic logic        flt;

      pde = (32'(pp) << 1) | (32'(a) << 5) | (32'(d) << 6) | (32'(n[2]) << 9);
      if (kind == 1) pde = pde | {10'(n * 7 + 3), 10'h155, 12'h000} | 32'h81;
      else           pde = pde | {tf, 12'h000} | ((kind == 0) ? (32'(n[3]) << 7) : 32'h1);
      pte = {20'(n * 1237 + 5), 12'h000} | (32'(qp) << 1) | (32'(d) << 5) | (32'(a) << 6)
            | (32'(n[5]) << 10) | ((kind == 3) ? 32'h1 : 32'h0);
      flt   = (kind == 0) || (kind == 2);
      xnr   = (kind <= 1) ? 1 : 2;
      pde_n = pde | 32'h20 | ((kind == 1 && wr) ? 32'h40 : 32'h0);
      pte_n = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
      if (!flt && pde_n != pde) begin xwa[xnw] = e1a; xwd[xnw] = pde_n; xnw++; end
      if (kind == 3 && pte_n != pte) begin xwa[xnw] = e2a; xwd[xnw] = pte_n; xnw++; end
      xpa = (kind == 1) ? {pde[31:22], va[21:0]} : (kind == 3) ? {pte[31:12], off} : 32'd0;
      xfl = (kind == 1) ? pde_n[11:0] : (kind == 3) ? pte_n[11:0] : 12'd0;
      xpm = (kind == 1) ? pde[2:1] : (kind == 3) ? (pde[2:1] & pte[2:1]) : 2'd0;

      mem[e1a[13:2]] = pde;
      mem[e2a[13:2]] = pte;
      lat = 1 + (n % 3);
      r0 = rcnt;
      w0 = wcnt;
      req_va = va; req_write = wr; req_user = us; req_valid = 1'b1;
      @(posedge clk);
      #1;
      req_va = ~va; req_write = ~wr; req_user = ~us;
      t = 0;
      do begin
        @(negedge clk);
        t++;
      end while (!resp_valid && t < 100);
      req_valid = 1'b0;

      chk("R8 response seen", 32'(resp_valid), 32'd1);
      chk("R4 fault flag", 32'(resp_fault), 32'(flt));
      chk(kind == 1 ? "R3 large pa" : "R2 page pa", resp_pa, xpa);
      chk("R3 large flag", 32'(resp_large), 32'(kind == 1));
      chk("R7 flags", 32'(resp_flags), 32'(xfl));
      chk("R7 perm", 32'(resp_perm), 32'(xpm));
      chk("R8 user echo", 32'(resp_user), 32'(us));
      chk("R1 R9 read count", 32'(rcnt - r0), 32'(xnr));
      chk("R1 first read addr", radr[r0 % 4], e1a);
      if (xnr == 2) chk("R1 second read addr", radr[(r0 + 1) % 4], e2a);
      chk("R5 R4 write count", 32'(wcnt - w0), 32'(xnw));
      for (int k = 0; k < xnw && k < 2; k++) begin
        chk("R6 write order addr", wadr[(w0 + k) % 4], xwa[k]);
        chk("R5 write data", wdat[(w0 + k) % 4], xwd[k]);
      end
      chk("R5 first entry in memory", mem[e1a[13:2]], flt ? pde : pde_n);
      chk("R5 second entry in memory", mem[e2a[13:2]], (kind == 3) ? pte_n : pte);
      @(negedge clk);
      chk("R8 ready after response", 32'(req_ready), 32'd1);
      chk("R8 single pulse", 32'(resp_valid), 32'd0);
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule